// File: doc/BRIEF.md
# PTP Time-of-Day Counter with Fractional Increment

This block keeps a free-running time of day for a precision time protocol (IEEE 1588) engine. It holds a nanosecond count below one billion and a 48-bit seconds count, kept as a 32-bit low word and a 16-bit high word. On every clock the nanosecond count grows by a programmable step. The step is a whole number of nanoseconds plus a 24-bit binary fraction. The fraction builds up in an accumulator, and each carry out of that accumulator adds one more nanosecond to the step.

Software reaches the counter through a 32-bit register port with single-cycle write and read strobes and an address. It can load the nanosecond value and each seconds word on its own, read every time word live, and program the increment. It can also apply a one-time signed nanosecond offset, which carries into the seconds or borrows from them. A fraction write is held in a staging register. It takes effect only when the whole-nanosecond increment is written. Frequency trimming is done by software rewriting the increment.

Register map (word addresses): 0 nanoseconds, 1 seconds low word, 2 seconds high word, 3 whole-ns increment, 4 fraction increment, 5 offset.

Top module: `ptp_time_counter`

## Requirements
- R1: Synchronous reset clears the nanosecond and seconds counts, both increments, the staged fraction and the accumulator, so every register reads 0 after reset.
- R2: On each cycle with no time write, the nanosecond count grows by the whole-ns increment plus one when the 24-bit accumulator (accumulator + active fraction) carries out. For example, an increment of 8 with a fraction of 0x800000 gives steps that alternate between 8 and 9.
- R3: At address 4, bits [15:0] carry fraction bits [23:8], bits [31:24] carry fraction bits [7:0], and bits [23:16] are ignored. The active fraction reads back in the same layout, with bits [23:16] read as 0.
- R4: A write to address 4 only stages the fraction. The active fraction and the time rate do not change until address 3 is written. A write to address 3 sets the whole-ns increment from bits [7:0] and activates the staged fraction.
- R5: When the nanosecond count reaches 1,000,000,000 it wraps by that amount and the 48-bit seconds count goes up by one, carrying from the low word into the high word.
- R6: A write to address 1 replaces only the seconds low word. A write to address 2 replaces only the high word, from bits [15:0]. Neither write touches the other half.
- R7: A write to address 0 loads the nanosecond count directly, and writing 0 leaves the seconds unchanged. In any cycle that writes address 0, 1, 2 or 5, the time does not advance.
- R8: A write to address 5 with bit 31 clear adds the magnitude in bits [29:0] (below 1e9) to the time once. If the result reaches 1e9, it wraps and the seconds go up by one.
- R9: A write to address 5 with bit 31 set subtracts the magnitude once. If the result falls below zero, the nanosecond count becomes 1e9 plus the result and the 48-bit seconds count goes down by one.
- R10: While both the whole-ns increment and the active fraction are zero, the time stands still.
- R11: A read strobe returns, on rd_data in the next cycle, the live value the addressed register held at the strobe edge. The seconds high word is zero-extended, and addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, valid the cycle after rd_en |

## Verification
The assertions assume that software never loads a nanosecond value or an offset magnitude of 1e9 or more, and that read and write strobes name one address per cycle. The stimulus writes only nanosecond values and magnitudes below one billion. It drives strobes only one at a time, at the falling edge. The wrap checks for the nanosecond range and the seconds carry therefore hold only when those limits are respected.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

  localparam int unsigned NS_PER_SEC = 1_000_000_000;

  typedef enum logic [2:0] {
    RA_NS     = 3'd0,
    RA_SEC_LO = 3'd1,
    RA_SEC_HI = 3'd2,
    RA_INC_NS = 3'd3,
    RA_INC_FR = 3'd4,
    RA_OFFSET = 3'd5
  } reg_addr_e;

endpackage

// File: rtl/ptp_step_gen.sv
module ptp_step_gen #(
  parameter int INC_NS_W = 8,
  parameter int FRAC_W   = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hold,
  input  logic                stage_wr,
  input  logic [FRAC_W-1:0]   stage_val,
  input  logic                commit_wr,
  input  logic [INC_NS_W-1:0] inc_val,
  output logic [INC_NS_W:0]   step_ns,
  output logic [INC_NS_W-1:0] inc_ns_q,
  output logic [FRAC_W-1:0]   frac_act_q
);

  logic [FRAC_W-1:0] frac_stage;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   acc_sum;

  assign acc_sum = {1'b0, acc} + {1'b0, frac_act_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      frac_stage <= '0;
      frac_act_q <= '0;
      inc_ns_q   <= '0;
      acc        <= '0;
    end else begin
      if (stage_wr) frac_stage <= stage_val;
      if (commit_wr) begin
        inc_ns_q   <= inc_val;
        frac_act_q <= frac_stage;
      end
      if (!hold) acc <= acc_sum[FRAC_W-1:0];
    end
  end

  always_comb begin
    if (hold) step_ns = '0;
    else      step_ns = {1'b0, inc_ns_q} + {{INC_NS_W{1'b0}}, acc_sum[FRAC_W]};
  end

  // R4
  stage_only_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_wr && !commit_wr) |=> $stable(frac_act_q));

endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
  import ptp_tc_pkg::*;
#(
  parameter int NS_W   = 30,
  parameter int SEC_W  = 48,
  parameter int OFS_W  = 30,
  parameter int STEP_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STEP_W-1:0] step_ns,
  input  logic              ns_wr,
  input  logic [NS_W-1:0]   ns_val,
  input  logic              slo_wr,
  input  logic [31:0]       slo_val,
  input  logic              shi_wr,
  input  logic [SEC_W-33:0] shi_val,
  input  logic              ofs_wr,
  input  logic              ofs_neg,
  input  logic [OFS_W-1:0]  ofs_mag,
  output logic [NS_W-1:0]   ns_q,
  output logic [SEC_W-1:0]  sec_q
);

  localparam logic [NS_W:0] WRAP = (NS_W+1)'(NS_PER_SEC);

  logic [NS_W:0] adv_sum;
  logic [NS_W:0] ofs_add;
  logic [NS_W:0] ofs_sub;

  assign adv_sum = {1'b0, ns_q} + (NS_W+1)'(step_ns);
  assign ofs_add = {1'b0, ns_q} + (NS_W+1)'(ofs_mag);
  assign ofs_sub = {1'b0, ns_q} - (NS_W+1)'(ofs_mag);

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q  <= '0;
      sec_q <= '0;
    end else if (ns_wr) begin
      ns_q <= ns_val;
    end else if (slo_wr) begin
      sec_q[31:0] <= slo_val;
    end else if (shi_wr) begin
      sec_q[SEC_W-1:32] <= shi_val;
    end else if (ofs_wr) begin
      if (ofs_neg) begin
        if (ofs_sub[NS_W]) begin
          ns_q  <= NS_W'(ofs_sub + WRAP);
          sec_q <= sec_q - 1'b1;
        end else begin
          ns_q <= NS_W'(ofs_sub);
        end
      end else if (ofs_add >= WRAP) begin
        ns_q  <= NS_W'(ofs_add - WRAP);
        sec_q <= sec_q + 1'b1;
      end else begin
        ns_q <= NS_W'(ofs_add);
      end
    end else if (adv_sum >= WRAP) begin
      ns_q  <= NS_W'(adv_sum - WRAP);
      sec_q <= sec_q + 1'b1;
    end else begin
      ns_q <= NS_W'(adv_sum);
    end
  end

  // R5
  ns_range_chk: assert property (@(posedge clk) disable iff (rst)
    ns_q < NS_W'(NS_PER_SEC));

  // R6
  hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (rst)
    shi_wr |=> sec_q[31:0] == $past(sec_q[31:0]));

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int INC_NS_W = 8,
  parameter int FRAC_W   = 24,
  parameter int FRAC_LO_W = 8,
  parameter int NS_W     = 30,
  parameter int SEC_HI_W = 16,
  parameter int OFS_W    = 30
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rd_data
);

  localparam int SEC_W   = 32 + SEC_HI_W;
  localparam int STEP_W  = INC_NS_W + 1;
  localparam int FRAC_HI_W = FRAC_W - FRAC_LO_W;
  localparam int GAP_W   = 32 - FRAC_W;

  logic                wr_ns, wr_slo, wr_shi, wr_inc, wr_frac, wr_ofs, hold;
  logic [STEP_W-1:0]   step_ns;
  logic [INC_NS_W-1:0] inc_ns_q;
  logic [FRAC_W-1:0]   frac_act_q;
  logic [FRAC_W-1:0]   stage_val;
  logic [NS_W-1:0]     ns_q;
  logic [SEC_W-1:0]    sec_q;

  assign wr_ns   = wr_en && (addr == RA_NS);
  assign wr_slo  = wr_en && (addr == RA_SEC_LO);
  assign wr_shi  = wr_en && (addr == RA_SEC_HI);
  assign wr_inc  = wr_en && (addr == RA_INC_NS);
  assign wr_frac = wr_en && (addr == RA_INC_FR);
  assign wr_ofs  = wr_en && (addr == RA_OFFSET);
  assign hold    = wr_ns || wr_slo || wr_shi || wr_ofs;

  // upper fraction bits sit low in the word, lower fraction bits sit in the top byte
  assign stage_val = {wdata[FRAC_HI_W-1:0], wdata[31 -: FRAC_LO_W]};

  ptp_step_gen #(.INC_NS_W(INC_NS_W), .FRAC_W(FRAC_W)) u_step (
    .clk        (clk),
    .rst        (rst),
    .hold       (hold),
    .stage_wr   (wr_frac),
    .stage_val  (stage_val),
    .commit_wr  (wr_inc),
    .inc_val    (wdata[INC_NS_W-1:0]),
    .step_ns    (step_ns),
    .inc_ns_q   (inc_ns_q),
    .frac_act_q (frac_act_q)
  );

  ptp_tod_core #(.NS_W(NS_W), .SEC_W(SEC_W), .OFS_W(OFS_W), .STEP_W(STEP_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .step_ns (step_ns),
    .ns_wr   (wr_ns),
    .ns_val  (wdata[NS_W-1:0]),
    .slo_wr  (wr_slo),
    .slo_val (wdata),
    .shi_wr  (wr_shi),
    .shi_val (wdata[SEC_HI_W-1:0]),
    .ofs_wr  (wr_ofs),
    .ofs_neg (wdata[31]),
    .ofs_mag (wdata[OFS_W-1:0]),
    .ns_q    (ns_q),
    .sec_q   (sec_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (addr)
        RA_NS:     rd_data <= 32'(ns_q);
        RA_SEC_LO: rd_data <= sec_q[31:0];
        RA_SEC_HI: rd_data <= 32'(sec_q[SEC_W-1:32]);
        RA_INC_NS: rd_data <= 32'(inc_ns_q);
        RA_INC_FR: rd_data <= {frac_act_q[FRAC_LO_W-1:0], {GAP_W{1'b0}},
                               frac_act_q[FRAC_W-1:FRAC_LO_W]};
        default:   rd_data <= '0;
      endcase
    end
  end

  // R10
  still_time_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_ns_q == '0 && frac_act_q == '0 && !wr_en) |=> ($stable(ns_q) && $stable(sec_q)));

  // R7
  zero_ns_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == RA_NS && wdata == 32'd0) |=> (ns_q == '0 && $stable(sec_q)));

endmodule

// File: tb/ptp_time_counter_test.sv
module ptp_time_counter_test;

  localparam int CLK_PERIOD = 10;
  localparam longint NSS = 1_000_000_000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_time_counter uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data)
  );

  // reference model built from the requirements
  longint      m_ns = 0;
  logic [47:0] m_sec = '0;
  logic [23:0] m_acc = '0, m_fact = '0, m_stage = '0;
  logic [7:0]  m_inc = '0;

  always @(posedge clk) begin
    longint t;
    logic [24:0] fs;
    if (rst) begin
      m_ns = 0; m_sec = '0; m_acc = '0; m_fact = '0; m_stage = '0; m_inc = '0;
    end else begin
      if (wr_en && (addr == 3'd0 || addr == 3'd1 || addr == 3'd2 || addr == 3'd5)) begin
        case (addr)
          3'd0: m_ns = longint'(wdata[29:0]);
          3'd1: m_sec[31:0] = wdata;
          3'd2: m_sec[47:32] = wdata[15:0];
          default: begin
            if (wdata[31]) begin
              t = m_ns - longint'(wdata[29:0]);
              if (t < 0) begin t = t + NSS; m_sec = m_sec - 48'd1; end
            end else begin
              t = m_ns + longint'(wdata[29:0]);
              if (t >= NSS) begin t = t - NSS; m_sec = m_sec + 48'd1; end
            end
            m_ns = t;
          end
        endcase
      end else begin
        fs = {1'b0, m_acc} + {1'b0, m_fact};
        m_acc = fs[23:0];
        t = m_ns + longint'(m_inc) + longint'(fs[24]);
        if (t >= NSS) begin t = t - NSS; m_sec = m_sec + 48'd1; end
        m_ns = t;
      end
      if (wr_en && addr == 3'd4) m_stage = {wdata[15:0], wdata[31:24]};
      if (wr_en && addr == 3'd3) begin m_inc = wdata[7:0]; m_fact = m_stage; end
    end
  end

  function automatic logic [31:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return 32'(m_ns);
      3'd1: return m_sec[31:0];
      3'd2: return {16'h0, m_sec[47:32]};
      3'd3: return {24'h0, m_inc};
      3'd4: return {m_fact[7:0], 8'h00, m_fact[23:8]};
      default: return 32'h0;
    endcase
  endfunction

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      total++;
      if (rd_data !== e) begin
        bad++;
        $display("FAIL %s: actual %h expected %h", tg, rd_data, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] a, input logic [31:0] e, input string tg);
    exp_q.push_back(e); tag_q.push_back(tg);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_mod(input logic [2:0] a, input string tg);
    exp_q.push_back(model_rd(a)); tag_q.push_back(tg);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual hang expected completion");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    for (int a = 0; a < 5; a++) rd_exp(3'(a), 32'h0, "R1 reset clears");

    // R10 static time with zero increments, R7 direct load
    wr(3'd0, 32'd123);
    idle(5);
    rd_exp(3'd0, 32'd123, "R10 time stands still");
    rd_exp(3'd1, 32'd0, "R10 seconds still");
    wr(3'd1, 32'd7);
    wr(3'd0, 32'd0);
    rd_exp(3'd1, 32'd7, "R7 zero ns write keeps seconds");
    rd_exp(3'd0, 32'd0, "R7 ns loaded");

    // R4 staging
    wr(3'd4, 32'h0000_8000);
    rd_exp(3'd4, 32'h0, "R4 fraction only staged");
    wr(3'd0, 32'd500);
    idle(3);
    rd_exp(3'd0, 32'd500, "R4 staged fraction does not advance time");
    wr(3'd3, 32'd8);
    rd_exp(3'd4, 32'h0000_8000, "R4 fraction active after commit");
    rd_exp(3'd3, 32'd8, "R4 whole ns increment");
    // R2 step 8 + one half
    for (int i = 0; i < 6; i++) rd_mod(3'd0, "R2 fractional stepping");
    idle(2);
    rd_mod(3'd0, "R2 fractional stepping after gap");

    // R3 register layout
    wr(3'd4, 32'hAB12_3456);
    wr(3'd3, 32'd3);
    rd_exp(3'd4, 32'hAB00_3456, "R3 fraction layout");
    rd_exp(3'd3, 32'd3, "R3 increment");
    for (int i = 0; i < 4; i++) rd_mod(3'd0, "R3 odd fraction stepping");

    // R5 wrap with low to high carry, running
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'd3);
    wr(3'd0, 32'd999_999_960);
    for (int i = 0; i < 8; i++) begin
      rd_mod(3'd0, "R5 ns near wrap");
      rd_mod(3'd1, "R5 seconds low");
      rd_mod(3'd2, "R5 seconds high");
    end

    // R5 explicit, step of exactly 1
    wr(3'd4, 32'h0);
    wr(3'd3, 32'd1);
    wr(3'd2, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, 32'd999_999_998);
    rd_exp(3'd0, 32'd999_999_998, "R5 before wrap");
    rd_exp(3'd0, 32'd999_999_999, "R5 last ns");
    rd_exp(3'd0, 32'd0, "R5 wrapped ns");
    rd_exp(3'd1, 32'd0, "R5 low word carried");
    rd_exp(3'd2, 32'd1, "R5 high word carried");
    rd_exp(3'd0, 32'd3, "R5 ns resumes");

    // R8 and R9 offsets with static time
    wr(3'd3, 32'd0);
    wr(3'd2, 32'd0);
    wr(3'd1, 32'd10);
    wr(3'd0, 32'd999_999_900);
    wr(3'd5, 32'd300);
    rd_exp(3'd0, 32'd200, "R8 add wraps ns");
    rd_exp(3'd1, 32'd11, "R8 add carries seconds");
    wr(3'd5, 32'h8000_0000 | 32'd500);
    rd_exp(3'd0, 32'd999_999_700, "R9 subtract borrows ns");
    rd_exp(3'd1, 32'd10, "R9 subtract borrows seconds");
    wr(3'd5, 32'h8000_0000 | 32'd100);
    rd_exp(3'd0, 32'd999_999_600, "R9 subtract without borrow");
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd1);
    wr(3'd0, 32'd5);
    wr(3'd5, 32'h8000_000A);
    rd_exp(3'd0, 32'd999_999_995, "R9 borrow across words ns");
    rd_exp(3'd1, 32'hFFFF_FFFF, "R9 borrow across words low");
    rd_exp(3'd2, 32'd0, "R9 borrow across words high");

    // R6 halves written separately
    wr(3'd1, 32'h0000_1234);
    wr(3'd2, 32'h0000_0055);
    rd_exp(3'd1, 32'h0000_1234, "R6 high write keeps low");
    wr(3'd1, 32'h0000_9999);
    rd_exp(3'd2, 32'h0000_0055, "R6 low write keeps high");
    rd_exp(3'd1, 32'h0000_9999, "R6 low loaded");

    // R11 live reads, R7 write cycle suppresses advance
    wr(3'd3, 32'd2);
    wr(3'd0, 32'd1000);
    rd_exp(3'd0, 32'd1000, "R7 load cycle does not advance");
    rd_exp(3'd0, 32'd1002, "R11 live ns read");
    rd_exp(3'd0, 32'd1004, "R11 live ns read");
    rd_exp(3'd6, 32'd0, "R11 unmapped address");
    rd_exp(3'd5, 32'd0, "R11 offset reads zero");
    rd_mod(3'd0, "R11 live read model");

    idle(3);
    done = 1'b1;
    finish_run();
  end

endmodule